// File: doc/BRIEF.md
# Bipolar Line Encoder With Violation Insertion

This block turns the transmit bit stream of one T1/E1 channel into two pulse-select signals, one for a positive mark and one for a negative mark, which steer an external line driver. With single rail selected, a plain NRZ stream is coded by alternate mark inversion. Long zero runs can optionally be replaced by HDB3 substitutions (four-zero runs, for E1) or B8ZS substitutions (eight-zero runs, for T1). With dual rail selected, the two data inputs already carry the positive and negative marks and are passed straight through.

All inputs are sampled on the falling edge of the transmit clock. Every bit then passes through a window of `DEPTH` symbol stages. This gives the encoder room to rewrite a zero run once the run is complete. Polarity is assigned only when a symbol leaves the window, so each mode has the same latency. In plain AMI, a rising edge on the auxiliary input forces the next mark to repeat the polarity of the previous pulse. This is used to test far-end violation detectors.

Top module: `bpl_encoder`

## Requirements
- R1: With `rail_dual`=1, the pair (`tx_d`,`tx_aux`) sets the pulse directly. 1/0 gives a positive pulse, 0/1 a negative pulse, and 0/0 or 1/1 a space. No zero-run substitution and no violation insertion occur in this mode.
- R2: With `rail_dual`=0 and `code_sel`=00 (AMI), each one is sent as a mark of opposite polarity to the previous pulse, and each zero is sent as no pulse. The first mark after reset is positive.
- R3: With `code_sel`=01 (HDB3), every fourth consecutive zero completes a substitution. The four bits become 000V if the count of ordinary marks since the last substitution (or since reset) is odd, and B00V if it is even. V repeats the polarity of the preceding pulse, and B takes the opposite polarity.
- R4: With `code_sel`=10 (B8ZS), every eighth consecutive zero completes a substitution. The eight bits become 000VB0VB, with V and B following the same polarity rules as in R3.
- R5: Zero runs shorter than the substitution length (three or fewer in HDB3, seven or fewer in B8ZS, any length in AMI) are sent as spaces.
- R6: In single rail AMI, `tx_aux` sampled low and then high at consecutive falling edges arms one violation. The next one sent, including a one sampled at that same edge, repeats the polarity of the previous pulse, and this one is negative if no pulse has been sent since reset. The armed request survives intervening zeros and is consumed by that single mark.
- R7: In single rail HDB3 or B8ZS, `tx_aux` has no effect. An edge seen there is not remembered when the mode later changes to AMI.
- R8: The pulse for a bit sampled at falling edge k appears on the outputs from edge k+`DEPTH` until edge k+`DEPTH`+1. This latency is the same in every mode.
- R9: An active-low asynchronous reset drives both outputs low, sets the polarity memory to negative and the HDB3 mark parity to even, and empties the window. `pulse_p` and `pulse_n` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock; all sampling on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rail_dual | input | 1 | 0 = single rail (encoded), 1 = dual rail (pass-through) |
| code_sel | input | 2 | Single rail code: 00 AMI, 01 HDB3, 10 B8ZS, 11 behaves as AMI |
| tx_d | input | 1 | NRZ data (single rail) or positive mark (dual rail) |
| tx_aux | input | 1 | Violation-insert request (single rail) or negative mark (dual rail) |
| pulse_p | output | 1 | Drive a positive pulse for this bit period |
| pulse_n | output | 1 | Drive a negative pulse for this bit period |

## Verification
The bench builds the encoder with `DEPTH`=8, the shallowest window that can hold a complete B8ZS substitution. At that depth the B and V of an eight-zero run land on the oldest stages, and any slot error shows at the outputs. The same depth fixes the expected latency at nine rising-edge samples after a bit is driven. That latency is measured directly, and it is also the offset used for every vector comparison. The runs include both HDB3 parities, a B8ZS run one zero short of substitution, violation requests held across zeros, and a mid-stream change from HDB3 to AMI.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

  localparam int HDB3_RUN = 4;
  localparam int B8ZS_RUN = 8;

  // Symbol kinds held in the window; polarity is resolved at the exit.
  typedef enum logic [2:0] {
    SYM_SPACE = 3'd0,
    SYM_BIP   = 3'd1,   // ordinary mark: opposite of last pulse
    SYM_VIOL  = 3'd2,   // violation: same as last pulse
    SYM_POS   = 3'd3,   // dual rail positive
    SYM_NEG   = 3'd4    // dual rail negative
  } sym_t;

  typedef enum logic [1:0] {
    CODE_AMI  = 2'd0,
    CODE_HDB3 = 2'd1,
    CODE_B8ZS = 2'd2,
    CODE_ALT  = 2'd3
  } code_t;

  function automatic sym_t dual_sym(input logic pos, input logic neg);
    case ({pos, neg})
      2'b10:   return SYM_POS;
      2'b01:   return SYM_NEG;
      default: return SYM_SPACE;
    endcase
  endfunction

  // Returns {positive, negative} for a symbol given the last pulse sign.
  function automatic logic [1:0] sym_pulse(input sym_t s, input logic last_pos);
    case (s)
      SYM_BIP:  return last_pos ? 2'b01 : 2'b10;
      SYM_VIOL: return last_pos ? 2'b10 : 2'b01;
      SYM_POS:  return 2'b10;
      SYM_NEG:  return 2'b01;
      default:  return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/lenc_bpv_gate.sv
module lenc_bpv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_en,
  input  logic bpv_in,
  input  logic mark_in,
  output logic viol_now
);

  logic aux_q;
  logic pend_q;
  logic bpv_rise;

  assign bpv_rise = arm_en && bpv_in && !aux_q;
  assign viol_now = arm_en && mark_in && (pend_q || bpv_rise);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      aux_q <= bpv_in;
      if (!arm_en || viol_now) pend_q <= 1'b0;
      else if (bpv_rise)       pend_q <= 1'b1;
    end
  end

  AST_BPV_ONE_SHOT: assert property (@(negedge clk) disable iff (!rst_n)
    viol_now |=> !pend_q); // R6
  AST_BPV_ARMS: assert property (@(negedge clk) disable iff (!rst_n)
    (bpv_rise && !mark_in) |=> pend_q); // R6
  AST_BPV_IDLE_CLEAR: assert property (@(negedge clk) disable iff (!rst_n)
    !arm_en |=> !pend_q); // R7

endmodule

// File: rtl/lenc_sym_window.sv
module lenc_sym_window
  import lenc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rail_dual,
  input  code_t code,
  input  logic  data_in,
  input  logic  aux_in,
  input  logic  viol_now,
  output sym_t  tail_sym
);

  localparam int ZW = $clog2(B8ZS_RUN);

  sym_t          win_q [DEPTH];
  sym_t          win_d [DEPTH];
  sym_t          entry;
  logic [ZW-1:0] zrun_q, zrun_d;
  logic          par_q, par_d;
  logic          single_hdb3, single_b8zs;
  logic          hdb3_hit, b8zs_hit;

  assign single_hdb3 = !rail_dual && (code == CODE_HDB3);
  assign single_b8zs = !rail_dual && (code == CODE_B8ZS);
  assign hdb3_hit    = single_hdb3 && !data_in && (zrun_q == ZW'(HDB3_RUN - 1));
  assign b8zs_hit    = single_b8zs && !data_in && (zrun_q == ZW'(B8ZS_RUN - 1));

  always_comb begin
    if (rail_dual)    entry = dual_sym(data_in, aux_in);
    else if (data_in) entry = viol_now ? SYM_VIOL : SYM_BIP;
    else              entry = SYM_SPACE;

    win_d[0] = entry;
    for (int i = 1; i < DEPTH; i++) win_d[i] = win_q[i-1];

    if (hdb3_hit) begin
      win_d[0] = SYM_VIOL;
      if (!par_q) win_d[HDB3_RUN-1] = SYM_BIP;
    end
    if (b8zs_hit) begin
      win_d[0] = SYM_BIP;
      win_d[1] = SYM_VIOL;
      win_d[3] = SYM_BIP;
      win_d[4] = SYM_VIOL;
    end
  end

  always_comb begin
    if ((single_hdb3 || single_b8zs) && !data_in && !hdb3_hit && !b8zs_hit)
      zrun_d = zrun_q + ZW'(1);
    else
      zrun_d = '0;
    if (hdb3_hit)                par_d = 1'b0;
    else if (!rail_dual && data_in) par_d = !par_q;
    else                         par_d = par_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) win_q[i] <= SYM_SPACE;
      zrun_q <= '0;
      par_q  <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) win_q[i] <= win_d[i];
      zrun_q <= zrun_d;
      par_q  <= par_d;
    end
  end

  assign tail_sym = win_q[DEPTH-1];

  AST_HDB3_RUN_RESTART: assert property (@(negedge clk) disable iff (!rst_n)
    hdb3_hit |=> (zrun_q == '0) && !par_q); // R3
  AST_B8ZS_GAPS_KEPT: assert property (@(negedge clk) disable iff (!rst_n)
    b8zs_hit |=> (win_q[2] == SYM_SPACE) && (win_q[5] == SYM_SPACE)); // R4
  AST_DUAL_NO_RUN: assert property (@(negedge clk) disable iff (!rst_n)
    rail_dual |=> (zrun_q == '0)); // R1

endmodule

// File: rtl/lenc_pol_stage.sv
module lenc_pol_stage
  import lenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sym_t sym_in,
  output logic pulse_p,
  output logic pulse_n
);

  logic       last_pos_q;
  logic [1:0] pulse_d;

  assign pulse_d = sym_pulse(sym_in, last_pos_q);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_p    <= 1'b0;
      pulse_n    <= 1'b0;
      last_pos_q <= 1'b0;
    end else begin
      pulse_p <= pulse_d[1];
      pulse_n <= pulse_d[0];
      if (sym_in != SYM_SPACE) last_pos_q <= pulse_d[1];
    end
  end

  AST_NO_DOUBLE_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
    !(pulse_p && pulse_n)); // R9
  AST_MARK_ALTERNATES: assert property (@(negedge clk) disable iff (!rst_n)
    (sym_in == SYM_BIP) |=> (pulse_p != $past(last_pos_q)) && (pulse_p || pulse_n)); // R2
  AST_VIOL_REPEATS: assert property (@(negedge clk) disable iff (!rst_n)
    (sym_in == SYM_VIOL) |=> (pulse_p == $past(last_pos_q)) && (pulse_p || pulse_n)); // R6

endmodule

// File: rtl/bpl_encoder.sv
module bpl_encoder
  import lenc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rail_dual,
  input  logic [1:0] code_sel,
  input  logic       tx_d,
  input  logic       tx_aux,
  output logic       pulse_p,
  output logic       pulse_n
);

  code_t code;
  logic  ami_single;
  logic  viol_now;
  sym_t  tail_sym;

  assign code       = code_t'(code_sel);
  assign ami_single = !rail_dual && ((code == CODE_AMI) || (code == CODE_ALT));

  lenc_bpv_gate u_bpv (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_en   (ami_single),
    .bpv_in   (tx_aux),
    .mark_in  (tx_d),
    .viol_now (viol_now)
  );

  lenc_sym_window #(.DEPTH(DEPTH)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .rail_dual (rail_dual),
    .code      (code),
    .data_in   (tx_d),
    .aux_in    (tx_aux),
    .viol_now  (viol_now),
    .tail_sym  (tail_sym)
  );

  lenc_pol_stage u_pol (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_in  (tail_sym),
    .pulse_p (pulse_p),
    .pulse_n (pulse_n)
  );

  AST_VIOL_ONLY_AMI: assert property (@(negedge clk) disable iff (!rst_n)
    viol_now |-> ami_single && tx_d); // R7

endmodule

// File: tb/bpl_encoder_tb.sv
module bpl_encoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int NV         = 10;

  // {rail, code[1:0], data[11:0], aux[11:0], expP[11:0], expN[11:0]}, bit 11 first in time
  localparam logic [50:0] VECS [NV] = '{
    {1'b0, 2'b00, 12'b110110000011, 12'b000000000000, 12'b100100000010, 12'b010010000001},
    {1'b0, 2'b01, 12'b100001000011, 12'b000000000000, 12'b100010000010, 12'b000001000101},
    {1'b0, 2'b01, 12'b000000001100, 12'b000000000000, 12'b100100001000, 12'b000010010100},
    {1'b0, 2'b10, 12'b100000000100, 12'b000000000000, 12'b100010001000, 12'b000001010100},
    {1'b0, 2'b10, 12'b100000001111, 12'b000000000000, 12'b100000000101, 12'b000000001010},
    {1'b0, 2'b00, 12'b111101110011, 12'b001111001000, 12'b100100100001, 12'b011001010010},
    {1'b0, 2'b01, 12'b111000011111, 12'b010101010101, 12'b101000101010, 12'b010000010101},
    {1'b1, 2'b00, 12'b101100101011, 12'b011001001100, 12'b100100100011, 12'b010001000100},
    {1'b1, 2'b01, 12'b000000001000, 12'b000000000000, 12'b000000001000, 12'b000000000000},
    {1'b0, 2'b00, 12'b110000000001, 12'b100000000000, 12'b010000000000, 12'b100000000001}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rail_dual = 1'b0;
  logic [1:0] code_sel = 2'b00;
  logic       tx_d = 1'b0;
  logic       tx_aux = 1'b0;
  logic       pulse_p, pulse_n;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpl_encoder #(.DEPTH(DEPTH)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rail_dual (rail_dual),
    .code_sel  (code_sel),
    .tx_d      (tx_d),
    .tx_aux    (tx_aux),
    .pulse_p   (pulse_p),
    .pulse_n   (pulse_n)
  );

  function automatic string vec_req(input int i);
    case (i)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5, 9: return "R6";
      6: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Reset, then drive 12 bits (code switches to code1 from bit sw), flush with ones.
  task automatic run_stream(input logic rail, input logic [1:0] code0, input logic [1:0] code1,
                            input int sw, input logic [11:0] d, input logic [11:0] a,
                            output logic [11:0] gp, output logic [11:0] gn);
    rst_n = 1'b0;
    rail_dual = rail;
    code_sel = code0;
    tx_d = 1'b0;
    tx_aux = 1'b0;
    gp = '0;
    gn = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 12 + DEPTH + 1; c++) begin
      if (c >= DEPTH + 1) begin
        gp[11 - (c - DEPTH - 1)] = pulse_p;
        gn[11 - (c - DEPTH - 1)] = pulse_n;
      end
      if (c < 12) begin
        tx_d = d[11 - c];
        tx_aux = a[11 - c];
        code_sel = (c >= sw) ? code1 : code0;
      end else begin
        tx_d = 1'b1;
        tx_aux = 1'b0;
      end
      @(posedge clk);
    end
  endtask

  initial begin
    logic [11:0] gp, gn;
    int lat;

    // R9: reset state
    repeat (2) @(posedge clk);
    check(!pulse_p && !pulse_n, "R9", {pulse_p, pulse_n}, 0);

    for (int v = 0; v < NV; v++) begin
      run_stream(VECS[v][50], VECS[v][49:48], VECS[v][49:48], 12,
                 VECS[v][47:36], VECS[v][35:24], gp, gn);
      check(gp == VECS[v][23:12], vec_req(v), gp, VECS[v][23:12]);
      check(gn == VECS[v][11:0],  vec_req(v), gn, VECS[v][11:0]);
    end

    // R7: edge seen in HDB3 must not arm a violation after switching to AMI
    run_stream(1'b0, 2'b01, 2'b00, 3, 12'b100110000000, 12'b010000000000, gp, gn);
    check(gp == 12'b100010000000, "R7", gp, 12'b100010000000);
    check(gn == 12'b000100000000, "R7", gn, 12'b000100000000);

    // R8: latency of a lone mark
    rst_n = 1'b0;
    rail_dual = 1'b0;
    code_sel = 2'b00;
    tx_d = 1'b0;
    tx_aux = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    tx_d = 1'b1;
    @(posedge clk);
    tx_d = 1'b0;
    lat = 1;
    while (!pulse_p && lat < 40) begin
      @(posedge clk);
      lat++;
    end
    check(lat == DEPTH + 1, "R8", lat, DEPTH + 1);
    @(posedge clk);
    check(!pulse_p && !pulse_n, "R8", {pulse_p, pulse_n}, 0);

    // R9: asynchronous reset mid-stream clears outputs
    tx_d = 1'b1;
    repeat (DEPTH + 4) @(posedge clk);
    check(pulse_p || pulse_n, "R2", {pulse_p, pulse_n}, 1);
    rst_n = 1'b0;
    #1;
    check(!pulse_p && !pulse_n, "R9", {pulse_p, pulse_n}, 0);
    tx_d = 1'b0;
    repeat (2) @(posedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule